// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block is a memory-mapped timer peripheral with two or three channels. Each channel has its own 32-bit down counter. A channel counts ticks of a prescaled copy of the input clock. When the counter underflows, it reloads from its own 32-bit reload value and raises a sticky underflow flag. The flag drives that channel's interrupt output whenever the interrupt enable is set.

All channels share one byte-wide start register, with one run bit per channel. Software reaches every register through a simple read/write port that supports byte, halfword and word accesses. Software typically uses the unit in one of three ways:
- A one-shot or periodic event source, acknowledging each interrupt by rewriting the control register with the flag bit at 0.
- A free-running timebase, with both the reload and the counter left at all ones. The bitwise inverse of the counter then rises steadily.
- A mix of the two, since the channels are independent.

Each channel is built around a two-state machine:
- **CH_STOP**: the prescaler phase is held at zero and the counter keeps its value.
- **CH_RUN**: the prescaler advances on every clock and issues a tick when it reaches the terminal count of the selected divider.

The state machine has two transitions:
- **start** (CH_STOP to CH_RUN): taken on the clock after the channel's start bit reads 1.
- **halt** (CH_RUN to CH_STOP): taken on the clock after the start bit reads 0.

Every other cycle holds the current state.

Top module: `tmu_timer_unit`

## Requirements
- R1: After reset, every reload and counter register reads 0xFFFFFFFF. Every control register reads 0 and the start register reads 0. All interrupt outputs are low.
- R2: The register map places the start byte at offset 4 in the default layout and at offset 2 when ALT_MAP=1. Channel n's block starts at 8+12n (default) or 4+12n (ALT_MAP=1). Within a block, the reload register is at +0, the counter at +4 and the 16-bit control register at +8. Control bits [2:0] hold the prescaler code, bit 5 is the interrupt enable and bit 8 is the underflow flag. All other control bits, unmapped bytes and start bits at or above NUM_CH read 0 and ignore writes.
- R3: bus_size selects the access width: 0 is a byte, 1 a halfword and 2 or 3 a word. Data is little-endian and right-aligned on bus_wdata and bus_rdata. A write changes only the bytes it addresses, and reads are combinational while bus_rd is high.
- R4: Start bit n runs channel n independently of the other channels. The start register is written at clock edge E. The channel first decrements at edge E+1+DIV and then every DIV clocks, where DIV is the selected divider.
- R5: Prescaler codes 0 to 4 divide by 4, 16, 64, 256 and 1024. Codes 5 to 7 read back as written and divide by 1024.
- R6: A tick with the counter at 0 loads the counter from the reload register and sets the underflow flag.
- R7: Writing control byte +9 with bit 0 at 0 clears the flag. Writing it with bit 0 at 1 leaves the flag unchanged. A hardware set in the same cycle as a clear leaves the flag at 1.
- R8: Each interrupt output equals that channel's flag AND its interrupt enable.
- R9: A stopped channel holds its counter and resets its prescaler phase. A restart therefore waits the full DIV+1 clocks of R4.
- R10: Writes to the counter or reload register take effect at the next edge, whether the channel runs or not. A counter write replaces that cycle's decrement or underflow.
- R11: With reload and counter at 0xFFFFFFFF, the counter wraps through the full 32-bit range, so its inverse increases monotonically between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Right-aligned write data |
| bus_rdata | output | 32 | Right-aligned read data, combinational |
| irq_o | output | NUM_CH | Per-channel underflow interrupt |

## Verification
The timing of each result is as follows:
- **Reads**: combinational, so each read is compared 1 ns after its address is driven on the falling edge.
- **Register writes**: a write sampled at rising edge E shows in the registers after E.
- **First decrement**: lands at edge E+1+DIV after the start-register write, because the state register adds one clock to the start bit. A halt likewise still allows a tick at edge E+1.
- **Interrupts**: an interrupt rises on the same edge that sets its flag.

A behavioural model in the bench applies these rules at every rising edge. The interrupt outputs are compared with it on every falling edge. Reads taken on consecutive cycles after a restart confirm the exact tick edge and the coincident set-and-clear case.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
    localparam int REG_W    = 32;
    localparam int PRE_W    = 10;
    localparam int CH_SPAN  = 12;
    localparam int CH_BYTES = 10;
    localparam int CNT_BYTE = 4;
    localparam int CTL_BYTE = 8;
    localparam int IE_BIT   = 5;
    localparam int FLAG_BIT = 8;

    typedef enum logic {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    // terminal prescaler phase for a divider code
    function automatic logic [PRE_W-1:0] pre_last(input logic [2:0] code);
        case (code)
            3'd0:    pre_last = PRE_W'(3);
            3'd1:    pre_last = PRE_W'(15);
            3'd2:    pre_last = PRE_W'(63);
            3'd3:    pre_last = PRE_W'(255);
            default: pre_last = PRE_W'(1023);
        endcase
    endfunction
endpackage

// File: rtl/tmu_regport.sv
module tmu_regport #(
    parameter int ADDR_W    = 6,
    parameter int MAP_BYTES = 44
) (
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [1:0]             bus_size,
    input  logic [31:0]            bus_wdata,
    input  logic [MAP_BYTES*8-1:0] img_i,
    output logic [MAP_BYTES-1:0]   be_o,
    output logic [MAP_BYTES*8-1:0] bdat_o,
    output logic [31:0]            rdata_o
);
    int nbytes;
    int d;
    int a;

    always_comb begin
        be_o    = '0;
        bdat_o  = '0;
        rdata_o = '0;
        d       = 0;
        a       = 0;
        nbytes  = (bus_size == 2'd0) ? 1 : ((bus_size == 2'd1) ? 2 : 4);
        for (int b = 0; b < MAP_BYTES; b++) begin
            d = b - int'(bus_addr);
            if (bus_wr && d >= 0 && d < nbytes) begin
                be_o[b]          = 1'b1;
                bdat_o[b*8 +: 8] = bus_wdata[d*8 +: 8];
            end
        end
        for (int j = 0; j < 4; j++) begin
            a = int'(bus_addr) + j;
            if (bus_rd && j < nbytes && a < MAP_BYTES)
                rdata_o[j*8 +: 8] = img_i[a*8 +: 8];
        end
    end
endmodule

// File: rtl/tmu_channel.sv
module tmu_channel
    import tmu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic [CH_BYTES-1:0]   wbe_i,
    input  logic [CH_BYTES*8-1:0] wdat_i,
    output logic [CH_BYTES*8-1:0] rimg_o,
    output logic                  irq_o,
    output logic                  running_o,
    output logic                  flag_o,
    output logic                  ie_o,
    output logic [REG_W-1:0]      cnt_o,
    output logic [REG_W-1:0]      rel_o
);
    ch_state_e        state_q, state_d;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic             tick;
    logic [REG_W-1:0] rel_q, rel_d, cnt_q, cnt_d;
    logic [2:0]       psc_q, psc_d;
    logic             ie_q, ie_d, flag_q, flag_d;
    logic             cnt_wr, uf, clr_req;
    logic             unused_wdat;

    assign unused_wdat = ^wdat_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_STOP;
        else        state_q <= state_d;
    end

    // transitions: start / halt
    always_comb begin
        unique case (state_q)
            CH_STOP: state_d = run_i ? CH_RUN : CH_STOP;
            CH_RUN:  state_d = run_i ? CH_RUN : CH_STOP;
            default: state_d = CH_STOP;
        endcase
    end

    // per-state outputs: prescaler phase and tick
    always_comb begin
        unique case (state_q)
            CH_STOP: begin
                tick  = 1'b0;
                pre_d = '0;
            end
            CH_RUN: begin
                tick  = (pre_q >= pre_last(psc_q));
                pre_d = tick ? '0 : pre_q + 1'b1;
            end
            default: begin
                tick  = 1'b0;
                pre_d = '0;
            end
        endcase
    end

    // counter, reload and control datapath
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            rel_d[k*8 +: 8] = wbe_i[k] ? wdat_i[k*8 +: 8] : rel_q[k*8 +: 8];
            cnt_d[k*8 +: 8] = wbe_i[CNT_BYTE+k] ? wdat_i[(CNT_BYTE+k)*8 +: 8]
                                                : cnt_q[k*8 +: 8];
        end
        cnt_wr = |wbe_i[CNT_BYTE +: 4];
        uf     = 1'b0;
        if (!cnt_wr && tick) begin
            if (cnt_q == '0) begin
                cnt_d = rel_q;
                uf    = 1'b1;
            end else begin
                cnt_d = cnt_q - 32'd1;
            end
        end
        psc_d = psc_q;
        ie_d  = ie_q;
        if (wbe_i[CTL_BYTE]) begin
            psc_d = wdat_i[CTL_BYTE*8 +: 3];
            ie_d  = wdat_i[CTL_BYTE*8 + IE_BIT];
        end
        clr_req = wbe_i[CTL_BYTE + FLAG_BIT/8] && !wdat_i[CTL_BYTE*8 + FLAG_BIT];
        flag_d  = uf | (flag_q & ~clr_req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            rel_q  <= '1;
            cnt_q  <= '1;
            psc_q  <= '0;
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            pre_q  <= pre_d;
            rel_q  <= rel_d;
            cnt_q  <= cnt_d;
            psc_q  <= psc_d;
            ie_q   <= ie_d;
            flag_q <= flag_d;
        end
    end

    assign rimg_o    = {7'b0, flag_q, 2'b0, ie_q, 2'b0, psc_q, cnt_q, rel_q};
    assign irq_o     = flag_q & ie_q;
    assign running_o = (state_q == CH_RUN);
    assign flag_o    = flag_q;
    assign ie_o      = ie_q;
    assign cnt_o     = cnt_q;
    assign rel_o     = rel_q;
endmodule

// File: rtl/tmu_timer_unit.sv
module tmu_timer_unit
    import tmu_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter bit ALT_MAP = 1'b0,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq_o
);
    localparam int START_OFF = ALT_MAP ? 2 : 4;
    localparam int CH_BASE   = ALT_MAP ? 4 : 8;
    localparam int MAP_BYTES = CH_BASE + CH_SPAN * NUM_CH;

    logic [NUM_CH-1:0]          start_q;
    logic [MAP_BYTES-1:0]       be;
    logic [MAP_BYTES*8-1:0]     bdat;
    logic [MAP_BYTES*8-1:0]     img;
    logic [NUM_CH*CH_BYTES*8-1:0] ch_img;
    logic [NUM_CH-1:0]          run_v, flag_v, ie_v;
    logic [NUM_CH*REG_W-1:0]    cnt_flat, rel_flat;
    logic                       unused_bdat;

    assign unused_bdat = ^{be, bdat};

    tmu_regport #(.ADDR_W(ADDR_W), .MAP_BYTES(MAP_BYTES)) u_port (
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .img_i(img),
        .be_o(be), .bdat_o(bdat), .rdata_o(bus_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             start_q <= '0;
        else if (be[START_OFF]) start_q <= bdat[START_OFF*8 +: NUM_CH];
    end

    always_comb begin
        img = '0;
        img[START_OFF*8 +: 8] = {{(8-NUM_CH){1'b0}}, start_q};
        for (int c = 0; c < NUM_CH; c++)
            img[(CH_BASE + CH_SPAN*c)*8 +: CH_BYTES*8] = ch_img[c*CH_BYTES*8 +: CH_BYTES*8];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int OFF = CH_BASE + CH_SPAN * g;
        tmu_channel u_ch (
            .clk(clk), .rst_n(rst_n), .run_i(start_q[g]),
            .wbe_i(be[OFF +: CH_BYTES]),
            .wdat_i(bdat[OFF*8 +: CH_BYTES*8]),
            .rimg_o(ch_img[g*CH_BYTES*8 +: CH_BYTES*8]),
            .irq_o(irq_o[g]), .running_o(run_v[g]),
            .flag_o(flag_v[g]), .ie_o(ie_v[g]),
            .cnt_o(cnt_flat[g*REG_W +: REG_W]),
            .rel_o(rel_flat[g*REG_W +: REG_W])
        );
    end
endmodule

// File: rtl/tmu_timer_chk.sv
module tmu_timer_chk #(
    parameter int NUM_CH = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [NUM_CH-1:0]  irq,
    input logic [NUM_CH-1:0]  run,
    input logic [NUM_CH-1:0]  flag,
    input logic [NUM_CH-1:0]  ie,
    input logic [NUM_CH*32-1:0] cnt,
    input logic [NUM_CH*32-1:0] rel
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // R6
        reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[n]) |-> cnt[n*32 +: 32] == $past(rel[n*32 +: 32]));
        // R9
        halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[n] && !bus_wr) |=> $stable(cnt[n*32 +: 32]));
        // R7
        flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[n]) |-> $past(bus_wr));
        // R8
        irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[n]) |-> ($rose(flag[n]) || $rose(ie[n])));
        // R4
        count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_wr && cnt[n*32 +: 32] != 32'd0) |=>
            (cnt[n*32 +: 32] == $past(cnt[n*32 +: 32]) ||
             cnt[n*32 +: 32] == $past(cnt[n*32 +: 32]) - 32'd1));
    end
endmodule

bind tmu_timer_unit tmu_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .irq(irq_o), .run(run_v),
    .flag(flag_v), .ie(ie_v), .cnt(cnt_flat), .rel(rel_flat)
);

// File: tb/tmu_timer_unit_test.sv
`timescale 1ns/1ps
module tmu_timer_unit_test;
    localparam int NCH = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [5:0]  bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata, bus_rdata;
    logic [NCH-1:0] irq;

    logic        a_wr, a_rd;
    logic [5:0]  a_addr;
    logic [1:0]  a_size;
    logic [31:0] a_wdata, a_rdata;
    logic [1:0]  a_irq;

    tmu_timer_unit #(.NUM_CH(NCH), .ALT_MAP(1'b0), .ADDR_W(6)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq));

    tmu_timer_unit #(.NUM_CH(2), .ALT_MAP(1'b1), .ADDR_W(6)) uut_alt (
        .clk(clk), .rst_n(rst_n), .bus_wr(a_wr), .bus_rd(a_rd),
        .bus_addr(a_addr), .bus_size(a_size), .bus_wdata(a_wdata),
        .bus_rdata(a_rdata), .irq_o(a_irq));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural model
    logic [31:0] m_rel [NCH];
    logic [31:0] m_cnt [NCH];
    logic [2:0]  m_psc [NCH];
    logic        m_ie  [NCH];
    logic        m_flag[NCH];
    logic        m_run [NCH];
    int          m_pre [NCH];
    logic [7:0]  m_start;

    always @(posedge clk) begin : model
        int div, nb, base, b, off;
        logic tick, cw, clr, uf;
        logic [7:0] d;
        logic [31:0] nrel, ncnt;
        logic [7:0] nstart;
        nb = (bus_size == 2'd0) ? 1 : ((bus_size == 2'd1) ? 2 : 4);
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_rel[c] = '1; m_cnt[c] = '1; m_psc[c] = 0; m_ie[c] = 0;
                m_flag[c] = 0; m_run[c] = 0; m_pre[c] = 0;
            end
            m_start = 0;
        end else begin
            nstart = m_start;
            for (int c = 0; c < NCH; c++) begin
                div  = (m_psc[c] < 5) ? (4 << (2 * m_psc[c])) : 1024;
                tick = m_run[c] && (m_pre[c] >= div - 1);
                base = 8 + 12 * c;
                nrel = m_rel[c]; ncnt = m_cnt[c]; cw = 0; clr = 0; uf = 0;
                if (bus_wr) begin
                    for (int k = 0; k < nb; k++) begin
                        b = int'(bus_addr) + k;
                        d = bus_wdata[k*8 +: 8];
                        off = b - base;
                        if (off >= 0 && off < 4) nrel[off*8 +: 8] = d;
                        if (off >= 4 && off < 8) begin ncnt[(off-4)*8 +: 8] = d; cw = 1; end
                        if (off == 8) begin m_psc[c] = d[2:0]; m_ie[c] = d[5]; end
                        if (off == 9) clr = !d[0];
                        if (c == 0 && b == 4) nstart = d & 8'h07;
                    end
                end
                if (!cw && tick) begin
                    if (m_cnt[c] == 0) begin ncnt = m_rel[c]; uf = 1; end
                    else ncnt = m_cnt[c] - 1;
                end
                m_flag[c] = uf ? 1'b1 : (clr ? 1'b0 : m_flag[c]);
                m_pre[c]  = m_run[c] ? (tick ? 0 : m_pre[c] + 1) : 0;
                m_run[c]  = m_start[c];
                m_rel[c]  = nrel;
                m_cnt[c]  = ncnt;
            end
            m_start = nstart;
        end
    end

    function automatic logic [7:0] mbyte(input int b);
        int off;
        mbyte = 8'h00;
        if (b == 4) mbyte = m_start;
        for (int c = 0; c < NCH; c++) begin
            off = b - (8 + 12 * c);
            if (off >= 0 && off < 4) mbyte = m_rel[c][off*8 +: 8];
            if (off >= 4 && off < 8) mbyte = m_cnt[c][(off-4)*8 +: 8];
            if (off == 8) mbyte = {2'b0, m_ie[c], 2'b0, m_psc[c]};
            if (off == 9) mbyte = {7'b0, m_flag[c]};
        end
    endfunction

    function automatic logic [31:0] mread(input int a, input logic [1:0] s);
        int nb;
        nb = (s == 2'd0) ? 1 : ((s == 2'd1) ? 2 : 4);
        mread = 0;
        for (int j = 0; j < nb; j++) mread[j*8 +: 8] = mbyte(a + j);
    endfunction

    // R8: interrupt outputs compared with the model every cycle
    always @(negedge clk) begin
        if (rst_n && !done)
            for (int c = 0; c < NCH; c++)
                check($sformatf("R8 irq ch%0d", c), {31'b0, irq[c]}, {31'b0, m_flag[c] & m_ie[c]});
    end

    task automatic wr(input int a, input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1; bus_addr = 6'(a); bus_size = s; bus_wdata = v;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input int a, input logic [1:0] s, input string tag, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1; bus_addr = 6'(a); bus_size = s;
        #1;
        v = bus_rdata;
        check(tag, bus_rdata, mread(a, s));
        #1 bus_rd = 0;
    endtask

    task automatic a_wrt(input int a, input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        a_wr = 1; a_addr = 6'(a); a_size = s; a_wdata = v;
        @(negedge clk);
        a_wr = 0;
    endtask

    task automatic a_chk(input int a, input logic [1:0] s, input logic [31:0] exp, input string tag);
        @(negedge clk);
        a_rd = 1; a_addr = 6'(a); a_size = s;
        #1 check(tag, a_rdata, exp);
        #1 a_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, v1, v2;
        rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_size = 0; bus_wdata = 0;
        a_wr = 0; a_rd = 0; a_addr = 0; a_size = 0; a_wdata = 0;
        idle(4);
        rst_n = 1;
        idle(1);

        // R1 reset values
        rd(4, 2'd0, "R1 start", v);
        rd(8, 2'd2, "R1 reload0", v);
        rd(24, 2'd2, "R1 counter1", v);
        rd(40, 2'd1, "R1 ctrl2", v);
        check("R1 irq", {29'b0, irq}, 32'h0);

        // R6 R4 underflow and reload on ch0 at divide by 4
        wr(8, 2'd2, 32'd5);
        wr(12, 2'd2, 32'd3);
        wr(16, 2'd1, 32'h0020);
        wr(4, 2'd0, 32'h01);
        for (int i = 0; i < 30; i++) rd(12, 2'd2, "R4 ch0 count timing", v);
        rd(16, 2'd1, "R6 ch0 flag", v);
        check("R6 flag set after wrap", v & 32'h100, 32'h100);

        // R7 acknowledge rules, channel halted first (R9)
        wr(4, 2'd0, 32'h00);
        idle(2);
        wr(17, 2'd0, 32'h01);
        rd(16, 2'd1, "R7 write one keeps flag", v);
        wr(17, 2'd0, 32'h00);
        rd(16, 2'd1, "R7 clear flag", v);
        check("R7 flag cleared", v & 32'h100, 32'h0);

        // R3 byte and halfword lanes
        wr(13, 2'd0, 32'hAB);
        rd(12, 2'd2, "R3 byte write lane", v);
        rd(13, 2'd0, "R3 byte read", v);
        wr(14, 2'd1, 32'h1234);
        rd(12, 2'd2, "R3 halfword write", v);
        rd(14, 2'd1, "R3 halfword read", v);
        rd(18, 2'd1, "R2 hole bytes", v);

        // R11 R5 free-running ch1 at divide by 16
        wr(28, 2'd1, 32'h0001);
        wr(4, 2'd0, 32'h02);
        idle(60);
        rd(24, 2'd2, "R11 free count a", v1);
        idle(100);
        rd(24, 2'd2, "R11 free count b", v2);
        check("R11 inverse rises", {31'b0, (~v2) > (~v1)}, 32'h1);

        // R9 halt holds counter, restart waits full phase
        wr(4, 2'd0, 32'h00);
        rd(24, 2'd2, "R9 halted a", v1);
        idle(50);
        rd(24, 2'd2, "R9 halted b", v2);
        check("R9 counter held", v2, v1);
        wr(4, 2'd0, 32'h0A);
        for (int i = 0; i < 40; i++) rd(24, 2'd2, "R9 restart timing", v);
        rd(4, 2'd0, "R2 start upper bits", v);

        // R5 reserved code on ch2 behaves as divide by 1024
        wr(32, 2'd2, 32'd1);
        wr(36, 2'd2, 32'd1);
        wr(40, 2'd1, 32'h0025);
        rd(40, 2'd1, "R5 reserved code readback", v);
        wr(4, 2'd0, 32'h04);
        idle(1020);
        rd(36, 2'd2, "R5 before first tick", v);
        idle(20);
        rd(36, 2'd2, "R5 after first tick", v);
        idle(2060);
        rd(40, 2'd1, "R5 R6 ch2 wrap", v);
        check("R5 ch2 flag", v & 32'h100, 32'h100);
        wr(4, 2'd0, 32'h00);

        // R7 set and clear in one cycle: ch0 wraps every tick
        wr(8, 2'd2, 32'd0);
        wr(12, 2'd2, 32'd0);
        wr(16, 2'd1, 32'h0020);
        wr(4, 2'd0, 32'h01);
        for (int i = 0; i < 24; i++) begin
            wr(17, 2'd0, 32'h00);
            if (i % 2 == 1) idle(1);
            rd(16, 2'd1, "R7 set wins over clear", v);
        end

        // R10 writes while running
        wr(8, 2'd2, 32'd7);
        wr(12, 2'd2, 32'd100);
        for (int i = 0; i < 12; i++) rd(12, 2'd2, "R10 counter write", v);
        wr(4, 2'd0, 32'h00);

        // R2 alternate layout, two channels
        a_chk(2, 2'd0, 32'h00, "R2 alt start reset");
        a_chk(20, 2'd2, 32'hFFFFFFFF, "R2 alt counter1 reset");
        a_wrt(20, 2'd2, 32'h12345678);
        a_chk(20, 2'd2, 32'h12345678, "R2 alt counter1 write");
        a_chk(22, 2'd1, 32'h00001234, "R3 alt halfword read");
        a_wrt(12, 2'd1, 32'h0000FFFF);
        a_chk(12, 2'd1, 32'h00000027, "R2 alt ctrl bits");
        a_chk(14, 2'd1, 32'h00000000, "R2 alt hole");
        a_wrt(2, 2'd0, 32'hFF);
        a_chk(2, 2'd0, 32'h03, "R4 alt start bits");

        idle(3);
        finish_run();
    end
endmodule